// File: doc/BRIEF.md
# Interrupt Source Routing Register Bank

This block keeps the configuration of every interrupt source in a multiprocessor interrupt controller. Each source owns two 32-bit words on a register bus. One is a vector/priority word, whose top bit masks the source. The other is a destination word that says which CPUs the source reaches, and whether it reaches each CPU as a normal or as a critical interrupt.

Each source has a raise input. While a source is raised and unmasked, the bank drives a normal or critical output for every CPU that its destination word selects. All sources are ORed onto one normal output and one critical output per CPU. Arbitration between sources, acknowledge and end-of-interrupt handling are left to the logic downstream.

Top module: `irq_route_bank`

## Requirements
- R1: After reset, the vector/priority word of every source reads 0x80800000, so bit 31 (the mask) is set.
- R2: After reset, the destination word of every source reads 0x00000001. The exception is the inter-processor sources, indices IPI_BASE up to IPI_BASE+IPI_NUM-1, whose destination word reads 0, so a raise on them drives no output.
- R3: An access with a legal address selects source index `bus_addr[ADDR_W-1:5]`, a 32-byte stride. Address bit 4 = 1 selects the destination word and 0 selects the vector/priority word. A write is stored at the clock edge. A read returns the stored word on `bus_rdata` in the cycle after `bus_rd`, and `bus_rdata` holds it until the next read.
- R4: An access with `bus_addr[3:0]` nonzero leaves every word unchanged on a write. On a read it returns 0xFFFFFFFF.
- R5: An access whose source index is NUM_SRC or above leaves every word unchanged on a write. On a read it returns 0xFFFFFFFF.
- R6: An access whose byte enables `bus_be` are not 4'hF leaves every word unchanged on a write. On a read it returns 0xFFFFFFFF.
- R7: A source whose vector/priority bit 31 is 1 drives no output, whether or not it is raised.
- R8: A raised, unmasked source whose destination bit (30 − n) is 1 drives `irq_crit[n]`. In that case it does not drive `irq_norm[n]`.
- R9: A raised, unmasked source whose destination bit (30 − n) is 0 and bit n is 1 drives `irq_norm[n]`.
- R10: Each output is the OR over all sources, registered. It reflects the raise inputs and the stored words as they stood at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_be | input | 4 | Byte enables; only 4'hF is decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| src_raise | input | NUM_SRC | Raise line per source |
| irq_norm | output | NUM_CPU | Normal interrupt output per CPU |
| irq_crit | output | NUM_CPU | Critical interrupt output per CPU |

## Verification
Read data appears one edge after the read strobe. A change on `src_raise` shows up on the outputs one edge later. A register write reaches the outputs two edges after the strobe: one edge to store the word and one to register the routing. The bench keeps a behavioural model that is updated at the same edges as the design. It compares outputs and read data at every falling edge, so each result is sampled in the cycle it is due. Directed checks add a literal expected value after each write, letting the extra edge settle first.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef logic [31:0] word_t;

  localparam word_t VP_RESET  = 32'h8080_0000;
  localparam word_t DE_RESET  = 32'h0000_0001;
  localparam int    MASK_POS  = 31;
  localparam int    CRIT_HIGH = 30;

  // critical route bit for a CPU counts down from CRIT_HIGH
  function automatic logic route_crit(word_t de, int cpu);
    return de[CRIT_HIGH - cpu];
  endfunction

  function automatic logic route_norm(word_t de, int cpu);
    return de[cpu] && !de[CRIT_HIGH - cpu];
  endfunction

  function automatic logic src_live(word_t vp, logic raise);
    return raise && !vp[MASK_POS];
  endfunction
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 16,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic              wr,
  output logic              acc_hit,
  output logic              sel_de,
  output logic [SEL_W-1:0]  src_idx,
  output logic [NUM_SRC-1:0] wr_vp_sel,
  output logic [NUM_SRC-1:0] wr_de_sel
);
  localparam int IDX_W = ADDR_W - 5;
  localparam logic [IDX_W-1:0] SRC_LIM = IDX_W'(NUM_SRC);

  logic aligned, full_word, in_range;

  assign aligned   = (addr[3:0] == 4'h0);
  assign full_word = (be == 4'hF);
  assign in_range  = (addr[ADDR_W-1:5] < SRC_LIM);
  assign acc_hit   = aligned && full_word && in_range;
  assign sel_de    = addr[4];
  assign src_idx   = addr[5 +: SEL_W];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sel
    assign wr_vp_sel[s] = wr && acc_hit && !sel_de && (src_idx == SEL_W'(s));
    assign wr_de_sel[s] = wr && acc_hit &&  sel_de && (src_idx == SEL_W'(s));
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int IPI_BASE = 6,
  parameter int IPI_NUM  = 2,
  localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       wr_vp_sel,
  input  logic [NUM_SRC-1:0]       wr_de_sel,
  input  word_t                    wdata,
  input  logic [SEL_W-1:0]         src_idx,
  input  logic                     sel_de,
  output logic [NUM_SRC-1:0][31:0] vp_q,
  output logic [NUM_SRC-1:0][31:0] de_q,
  output word_t                    rd_word
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam bit IS_IPI = (s >= IPI_BASE) && (s < IPI_BASE + IPI_NUM);
    localparam word_t DE_INIT = IS_IPI ? 32'h0 : DE_RESET;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vp_q[s] <= VP_RESET;
        de_q[s] <= DE_INIT;
      end else begin
        if (wr_vp_sel[s]) vp_q[s] <= wdata;
        if (wr_de_sel[s]) de_q[s] <= wdata;
      end
    end
  end

  always_comb rd_word = sel_de ? de_q[src_idx] : vp_q[src_idx];

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_vp_sel, wr_de_sel})); // R3
endmodule

// File: rtl/irq_route_fanout.sv
module irq_route_fanout
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_CPU = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0][31:0] vp_q,
  input  logic [NUM_SRC-1:0][31:0] de_q,
  input  logic [NUM_SRC-1:0]       src_raise,
  output logic [NUM_CPU-1:0]       irq_norm,
  output logic [NUM_CPU-1:0]       irq_crit
);
  logic [NUM_SRC-1:0] live;
  logic [NUM_CPU-1:0] norm_nx, crit_nx;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_live
    assign live[s] = src_live(vp_q[s], src_raise[s]);
  end

  always_comb begin
    norm_nx = '0;
    crit_nx = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (live[s] && route_crit(de_q[s], c)) crit_nx[c] = 1'b1;
        if (live[s] && route_norm(de_q[s], c)) norm_nx[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_norm <= '0;
      irq_crit <= '0;
    end else begin
      irq_norm <= norm_nx;
      irq_crit <= crit_nx;
    end
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |=> (irq_norm == '0 && irq_crit == '0)); // R7
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_CPU  = 2,
  parameter int IPI_BASE = 6,
  parameter int IPI_NUM  = 2,
  parameter int ADDR_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_raise,
  output logic [NUM_CPU-1:0] irq_norm,
  output logic [NUM_CPU-1:0] irq_crit
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic                     acc_hit, sel_de;
  logic [SEL_W-1:0]         src_idx;
  logic [NUM_SRC-1:0]       wr_vp_sel, wr_de_sel;
  logic [NUM_SRC-1:0][31:0] vp_q, de_q;
  word_t                    rd_word;

  irq_route_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .be(bus_be), .wr(bus_wr), .acc_hit(acc_hit),
    .sel_de(sel_de), .src_idx(src_idx),
    .wr_vp_sel(wr_vp_sel), .wr_de_sel(wr_de_sel)
  );

  irq_route_regs #(.NUM_SRC(NUM_SRC), .IPI_BASE(IPI_BASE), .IPI_NUM(IPI_NUM)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_vp_sel(wr_vp_sel), .wr_de_sel(wr_de_sel),
    .wdata(bus_wdata), .src_idx(src_idx), .sel_de(sel_de),
    .vp_q(vp_q), .de_q(de_q), .rd_word(rd_word)
  );

  irq_route_fanout #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_fan (
    .clk(clk), .rst_n(rst_n), .vp_q(vp_q), .de_q(de_q),
    .src_raise(src_raise), .irq_norm(irq_norm), .irq_crit(irq_crit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= acc_hit ? rd_word : 32'hFFFF_FFFF;
  end

  AST_RD_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !acc_hit) |=> (bus_rdata == 32'hFFFF_FFFF)); // R4
  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !acc_hit) |=> ($stable(vp_q) && $stable(de_q))); // R5
endmodule

// File: tb/irq_route_bank_tb.sv
module irq_route_bank_tb;
  localparam int NSRC = 8, NCPU = 2, IPIB = 6, IPIN = 2, AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0] bus_be = 4'hF;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NSRC-1:0] src_raise = '0;
  logic [NCPU-1:0] irq_norm, irq_crit;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_route_bank #(.NUM_SRC(NSRC), .NUM_CPU(NCPU), .IPI_BASE(IPIB),
    .IPI_NUM(IPIN), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_raise(src_raise),
    .irq_norm(irq_norm), .irq_crit(irq_crit));

  // behavioural reference
  logic [31:0] m_vp [NSRC];
  logic [31:0] m_de [NSRC];
  logic [31:0] m_rd;
  logic [NCPU-1:0] m_norm, m_crit;

  function automatic bit legal(logic [AW-1:0] a, logic [3:0] be);
    return (a[3:0] == 0) && (be == 4'hF) && (int'(a >> 5) < NSRC);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) begin
        m_vp[s] = 32'h8080_0000;
        m_de[s] = (s >= IPIB && s < IPIB + IPIN) ? 32'h0 : 32'h1;
      end
      m_rd = 0; m_norm = 0; m_crit = 0;
    end else begin
      m_norm = 0; m_crit = 0;
      for (int s = 0; s < NSRC; s++)
        if (src_raise[s] && !m_vp[s][31])
          for (int c = 0; c < NCPU; c++)
            if (m_de[s][30-c]) m_crit[c] = 1;
            else if (m_de[s][c]) m_norm[c] = 1;
      if (bus_rd) begin
        if (!legal(bus_addr, bus_be)) m_rd = 32'hFFFF_FFFF;
        else m_rd = bus_addr[4] ? m_de[int'(bus_addr >> 5)] : m_vp[int'(bus_addr >> 5)];
      end
      if (bus_wr && legal(bus_addr, bus_be)) begin
        if (bus_addr[4]) m_de[int'(bus_addr >> 5)] = bus_wdata;
        else m_vp[int'(bus_addr >> 5)] = bus_wdata;
      end
    end
  end

  // per-cycle comparison, R10 with R3 read timing
  always @(negedge clk) if (rst_n && !done) begin
    tests++;
    if (irq_norm !== m_norm || irq_crit !== m_crit || bus_rdata !== m_rd) begin
      fails++;
      $display("FAIL R10 cycle compare: norm=%b crit=%b rd=%h expected norm=%b crit=%b rd=%h",
               irq_norm, irq_crit, bus_rdata, m_norm, m_crit, m_rd);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk); bus_wr = 0; bus_be = 4'hF;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp,
                        input string tag, input logic [3:0] be = 4'hF);
    @(negedge clk); bus_rd = 1; bus_addr = a; bus_be = be;
    @(negedge clk); bus_rd = 0; bus_be = 4'hF;
    tests++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s read %h: got %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic out_chk(input logic [NCPU-1:0] en, input logic [NCPU-1:0] ec, input string tag);
    @(negedge clk);
    tests++;
    if (irq_norm !== en || irq_crit !== ec) begin
      fails++;
      $display("FAIL %s outputs: norm=%b crit=%b expected norm=%b crit=%b",
               tag, irq_norm, irq_crit, en, ec);
    end
  endtask

  function automatic logic [AW-1:0] va(int s); return AW'(s * 32); endfunction
  function automatic logic [AW-1:0] da(int s); return AW'(s * 32 + 16); endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    out_chk(2'b00, 2'b00, "R1 reset outputs");
    for (int s = 0; s < NSRC; s++) begin
      rd_chk(va(s), 32'h8080_0000, "R1");
      rd_chk(da(s), (s >= IPIB && s < IPIB + IPIN) ? 32'h0 : 32'h1, "R2");
    end
    // masked raise: nothing
    src_raise = 8'h01;
    out_chk(2'b00, 2'b00, "R7 masked after reset");
    wr(va(0), 32'h0000_0005);
    rd_chk(va(0), 32'h0000_0005, "R3 vp");
    out_chk(2'b01, 2'b00, "R9 normal cpu0");
    wr(da(0), 32'h4000_0001);
    rd_chk(da(0), 32'h4000_0001, "R3 de");
    out_chk(2'b00, 2'b01, "R8 critical wins cpu0");
    wr(va(1), 32'h0); wr(da(1), 32'h2000_0000);
    src_raise = 8'h03;
    @(negedge clk);
    out_chk(2'b00, 2'b11, "R8 critical cpu1");
    wr(va(2), 32'h0); wr(da(2), 32'h0000_0002);
    src_raise = 8'h07;
    @(negedge clk);
    out_chk(2'b10, 2'b11, "R10 OR of sources");
    wr(va(0), 32'h8000_0005);
    @(negedge clk);
    out_chk(2'b10, 2'b10, "R7 mask set");
    // misaligned
    wr(va(1) + 4, 32'h8000_0000);
    rd_chk(va(1), 32'h0, "R4 write ignored");
    rd_chk(va(1) + 8, 32'hFFFF_FFFF, "R4 read");
    out_chk(2'b10, 2'b10, "R4 outputs unchanged");
    // out of range
    wr(va(NSRC), 32'h1234_5678);
    rd_chk(va(NSRC), 32'hFFFF_FFFF, "R5 read");
    rd_chk(da(NSRC + 3), 32'hFFFF_FFFF, "R5 read de");
    // partial width
    wr(va(1), 32'h8000_0000, 4'h3);
    rd_chk(va(1), 32'h0, "R6 write ignored");
    rd_chk(va(1), 32'hFFFF_FFFF, "R6 read", 4'h8);
    out_chk(2'b10, 2'b10, "R6 outputs unchanged");
    // inter-processor source: cleared destination
    src_raise = 8'h40;
    wr(va(6), 32'h0);
    @(negedge clk);
    out_chk(2'b00, 2'b00, "R2 ipi quiet");
    wr(da(6), 32'h0000_0003);
    @(negedge clk);
    out_chk(2'b11, 2'b00, "R9 ipi both cpus");
    src_raise = 8'h00;
    @(negedge clk);
    out_chk(2'b00, 2'b00, "R10 drop");
    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule